// File: doc/BRIEF.md
# Watchdog Timer with Selectable Count Tick

This block is an 8-bit watchdog counter that counts up. Its count tick comes from one of three sources: a prescaled copy of the system clock, the undivided system clock, or a slow on-chip oscillator tick. A 4-bit select field in a mode register picks the source. A free-running prescaler supplies the divided ticks. The oscillator tick arrives as a pulse from another clock domain, and the block synchronizes it into the system clock domain before use.

When the counter rolls over from its highest value back to zero, the block sets a sticky watchdog-reset flag and emits a one-cycle internal reset pulse. Firmware reads and writes the counter, the mode register and a small control/status register over a simple register bus. The flag cannot be cleared by a stray store: a write clears it only while a stored write-enable bit is already 1, and only if that write places 0 in both the flag bit and its companion bit.

Top module: `watchdog_clksel`

## Requirements
- R1: While reset is asserted, the bus reads 0x00 from the counter (address 1), 0xFF from the mode register (address 2) and 0x7E from the control register (address 0), and `wdt_reset_o` is 0. Asserting reset also clears the flag.
- R2: A write to address 1 loads the counter on that clock edge. If a count tick falls on the same edge, the write wins over the increment.
- R3: When a tick moves the counter from 0xFF to 0x00, the flag (control bit 0) is set on the same edge and `wdt_reset_o` is high for exactly the one following cycle.
- R4: Once set, the flag stays at 1 after any control write that does not meet the clearing condition of R5.
- R5: A control write clears the flag only when the stored write-enable bit (control bit 7, loaded from write data bit 7 on every control write) is already 1 and the write data has bits 1 and 0 both at 0. Control bits 6 to 1 always read 1.
- R6: Mode bits 7 to 4 always read 1 and ignore writes. Mode bits 3 to 0 form the select field, which resets to 1111.
- R7: Select codes 1000 to 1110 advance the counter by one every 64, 128, 256, 512, 1024, 2048 and 8192 system clock cycles respectively.
- R8: Select code 1111 advances the counter by one on every system clock cycle.
- R9: Any select code with bit 3 at 0 advances the counter once per oscillator tick pulse and never otherwise. Bits 2 to 0 of the code are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick_i | input | 1 | Tick pulse from the slow oscillator, asynchronous to clk |
| bus_addr_i | input | 2 | Register address: 0 control, 1 counter, 2 mode |
| bus_wr_i | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the addressed register (combinational) |
| wdt_reset_o | output | 1 | One-cycle internal reset pulse after counter overflow |

## Verification
The bench builds the block with its default parameters: an 8-bit counter and a 13-bit prescaler. These are the smallest values that still provide every tap, so the full prescaler, up to the divide-by-8192 tap, is covered. All seven divided codes are swept, and for each one the bench measures the exact spacing between increments and compares it with a power of two it computes itself. The bench preloads the counter near 0xFF, which brings the overflow edge within a few cycles. Every path around the flag is driven: stores without the enable, with a partial bit pair, enabled clears, and clearing by reset.

// File: rtl/wdc_pkg.sv
// Shared definitions for the watchdog block: register addresses and the
// mapping from a divided select code to its prescaler tap width.
package wdc_pkg;

    localparam int DATA_W   = 8;
    localparam int NUM_TAPS = 7;

    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_CNT  = 2'd1,
        ADDR_MODE = 2'd2
    } wdc_addr_e;

    // Number of low prescaler bits that must wrap for tap index idx.
    function automatic int tap_shift(input int idx);
        case (idx)
            0:       return 6;
            1:       return 7;
            2:       return 8;
            3:       return 9;
            4:       return 10;
            5:       return 11;
            default: return 13;
        endcase
    endfunction

endpackage

// File: rtl/wdc_prescaler.sv
// Free-running prescaler. Assumes PRE_W covers the widest tap.
// Every tap gives a one-cycle enable on the cycle before its low bits wrap
// to zero, so tap i pulses once every 2**tap_shift(i) cycles.
module wdc_prescaler #(
    parameter int PRE_W = 13
) (
    input  logic                          clk,
    input  logic                          rst_n,
    output logic [wdc_pkg::NUM_TAPS-1:0]  tap_o
);
    logic [PRE_W-1:0] pre_q;

    // Purpose: advance the free-running prescale count.
    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_q + 1'b1;
    end

    for (genvar i = 0; i < wdc_pkg::NUM_TAPS; i++) begin : g_tap
        localparam int SHIFT = wdc_pkg::tap_shift(i);
        assign tap_o[i] = &pre_q[SHIFT-1:0];
    end
endmodule

// File: rtl/wdc_osc_sync.sv
// Brings the slow oscillator tick into the clk domain through two flops.
// It then turns each rising edge into a single-cycle enable.
// Assumes the oscillator pulse lasts at least one clk period.
module wdc_osc_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_i,
    output logic pulse_o
);
    localparam int CHAIN_W = SYNC_STAGES + 1;
    logic [CHAIN_W-1:0] chain_q;

    // Purpose: shift the raw tick through the synchronizer and edge stage.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[CHAIN_W-2:0], osc_i};
    end

    assign pulse_o = chain_q[CHAIN_W-2] & ~chain_q[CHAIN_W-1];
endmodule

// File: rtl/wdc_tick_sel.sv
// Picks the counter's count enable from the select field. Bit 3 low picks
// the oscillator tick, code 1111 picks every cycle, and the rest pick a tap.
module wdc_tick_sel (
    input  logic [3:0]                    sel_i,
    input  logic [wdc_pkg::NUM_TAPS-1:0]  tap_i,
    input  logic                          osc_pulse_i,
    output logic                          tick_o
);
    // Purpose: decode the select code into a single enable.
    always_comb begin
        if (!sel_i[3]) begin
            tick_o = osc_pulse_i;
        end else begin
            case (sel_i[2:0])
                3'd0:    tick_o = tap_i[0];
                3'd1:    tick_o = tap_i[1];
                3'd2:    tick_o = tap_i[2];
                3'd3:    tick_o = tap_i[3];
                3'd4:    tick_o = tap_i[4];
                3'd5:    tick_o = tap_i[5];
                3'd6:    tick_o = tap_i[6];
                default: tick_o = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/wdc_counter.sv
// Holds the watchdog count, the sticky flag, the write-enable bit and the
// reset pulse. A bus write beats a tick. The flag is set on the wrap edge,
// and setting wins over a clear on the same edge.
module wdc_counter #(
    parameter int CNT_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        tick_i,
    input  logic                        cnt_wr_i,
    input  logic                        ctrl_wr_i,
    input  logic [wdc_pkg::DATA_W-1:0]  wdata_i,
    output logic [CNT_W-1:0]            cnt_o,
    output logic                        flag_o,
    output logic                        wen_o,
    output logic                        rst_pulse_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic overflow;
    logic clear_req;

    assign overflow  = tick_i && !cnt_wr_i && (cnt_o == CNT_MAX);
    assign clear_req = ctrl_wr_i && wen_o && (wdata_i[1:0] == 2'b00);

    // Purpose: load or advance the watchdog count.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_o <= '0;
        else if (cnt_wr_i) cnt_o <= wdata_i[CNT_W-1:0];
        else if (tick_i)   cnt_o <= cnt_o + 1'b1;
    end

    // Purpose: keep the sticky flag, setting it on overflow ahead of a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)         flag_o <= 1'b0;
        else if (overflow)  flag_o <= 1'b1;
        else if (clear_req) flag_o <= 1'b0;
    end

    // Purpose: store the write-enable bit from each control write.
    always_ff @(posedge clk) begin
        if (!rst_n)         wen_o <= 1'b0;
        else if (ctrl_wr_i) wen_o <= wdata_i[7];
    end

    // Purpose: drive the one-cycle internal reset pulse after a wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) rst_pulse_o <= 1'b0;
        else        rst_pulse_o <= overflow;
    end
endmodule

// File: rtl/watchdog_clksel.sv
// Top of the watchdog: the mode register, address decode, the read mux and
// the submodules. Reads are combinational from the addressed register.
module watchdog_clksel #(
    parameter int PRE_W       = 13,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_tick_i,
    input  logic [1:0] bus_addr_i,
    input  logic       bus_wr_i,
    input  logic [7:0] bus_wdata_i,
    output logic [7:0] bus_rdata_o,
    output logic       wdt_reset_o
);
    import wdc_pkg::*;

    localparam int CNT_W = DATA_W;

    logic [3:0]          sel_q;
    logic [NUM_TAPS-1:0] taps;
    logic                osc_pulse;
    logic                tick;
    logic [CNT_W-1:0]    cnt_q;
    logic                flag_q;
    logic                we_q;
    logic                cnt_wr;
    logic                ctrl_wr;
    logic                mode_wr;

    assign cnt_wr  = bus_wr_i && (bus_addr_i == ADDR_CNT);
    assign ctrl_wr = bus_wr_i && (bus_addr_i == ADDR_CTRL);
    assign mode_wr = bus_wr_i && (bus_addr_i == ADDR_MODE);

    // Purpose: hold the select field; the reserved bits are not stored.
    always_ff @(posedge clk) begin
        if (!rst_n)       sel_q <= 4'hF;
        else if (mode_wr) sel_q <= bus_wdata_i[3:0];
    end

    wdc_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .tap_o (taps)
    );

    wdc_osc_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .osc_i   (osc_tick_i),
        .pulse_o (osc_pulse)
    );

    wdc_tick_sel u_sel (
        .sel_i       (sel_q),
        .tap_i       (taps),
        .osc_pulse_i (osc_pulse),
        .tick_o      (tick)
    );

    wdc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .cnt_wr_i    (cnt_wr),
        .ctrl_wr_i   (ctrl_wr),
        .wdata_i     (bus_wdata_i),
        .cnt_o       (cnt_q),
        .flag_o      (flag_q),
        .wen_o       (we_q),
        .rst_pulse_o (wdt_reset_o)
    );

    // Purpose: return the addressed register on the read bus.
    always_comb begin
        case (bus_addr_i)
            ADDR_CTRL: bus_rdata_o = {we_q, 6'b111111, flag_q};
            ADDR_CNT:  bus_rdata_o = cnt_q;
            ADDR_MODE: bus_rdata_o = {4'hF, sel_q};
            default:   bus_rdata_o = 8'h00;
        endcase
    end
endmodule

// File: rtl/wdc_checker.sv
// Timing properties of the watchdog, bound onto the top module.
module wdc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] bus_addr,
    input logic       bus_wr,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input logic       flag,
    input logic       we,
    input logic [7:0] cnt,
    input logic       rst_pulse
);
    // R3
    pulse_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pulse |-> flag);

    // R3
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pulse |=> !rst_pulse);

    // R3
    pulse_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pulse |-> cnt == 8'h00);

    // R4
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !(bus_wr && bus_addr == 2'd0 && we && bus_wdata[1:0] == 2'b00))
        |=> flag);

    // R2
    cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd1) |=> cnt == $past(bus_wdata));

    // R6
    mode_rsv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 2'd2) |-> bus_rdata[7:4] == 4'hF);
endmodule

bind watchdog_clksel wdc_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr_i),
    .bus_wr    (bus_wr_i),
    .bus_wdata (bus_wdata_i),
    .bus_rdata (bus_rdata_o),
    .flag      (flag_q),
    .we        (we_q),
    .cnt       (cnt_q),
    .rst_pulse (wdt_reset_o)
);

// File: tb/sim_watchdog_clksel.sv
module sim_watchdog_clksel;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_tick_i = 1'b0;
    logic [1:0] bus_addr_i = 2'd0;
    logic       bus_wr_i = 1'b0;
    logic [7:0] bus_wdata_i = 8'h00;
    logic [7:0] bus_rdata_o;
    logic       wdt_reset_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    watchdog_clksel u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .osc_tick_i  (osc_tick_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wr_i    (bus_wr_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .wdt_reset_o (wdt_reset_o)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr_i = a; bus_wdata_i = d; bus_wr_i = 1'b1;
        @(negedge clk);
        bus_wr_i = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr_i = a;
        #1 d = bus_rdata_o;
    endtask

    task automatic osc_pulse();
        @(negedge clk); osc_tick_i = 1'b1;
        @(negedge clk); osc_tick_i = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, prev;
        int t0, per;
        bit seen;

        // R1: values during reset
        repeat (3) @(negedge clk);
        rd(2'd1, v); check("R1 cnt", v, 8'h00);
        rd(2'd2, v); check("R1 mode", v, 8'hFF);
        rd(2'd0, v); check("R1 ctrl", v, 8'h7E);
        check("R1 pulse", wdt_reset_o, 0);
        rst_n = 1'b1;

        // R2: write beats the every-cycle tick; R8 then counts each cycle
        wr(2'd1, 8'h40);
        rd(2'd1, v); check("R2 load", v, 8'h40);
        for (int i = 1; i <= 4; i++) begin
            @(negedge clk); rd(2'd1, v); check("R8 step", v, 8'h40 + i);
        end

        // R3: overflow sets flag and one-cycle pulse
        wr(2'd1, 8'hFD);
        seen = 1'b0;
        for (int i = 0; i < 6 && !seen; i++) begin
            @(negedge clk); rd(2'd1, v);
            if (v == 8'h00) begin
                seen = 1'b1;
                check("R3 pulse high", wdt_reset_o, 1);
                @(negedge clk);
                check("R3 pulse low", wdt_reset_o, 0);
            end
        end
        check("R3 wrap seen", seen, 1);
        wr(2'd2, 8'h00);
        rd(2'd0, v); check("R3 flag", v, 8'h7F);

        // R4: non-clearing writes leave the flag set
        wr(2'd0, 8'h00); rd(2'd0, v); check("R4 no enable", v, 8'h7F);
        wr(2'd0, 8'h80); rd(2'd0, v); check("R4 enable first", v, 8'hFF);
        wr(2'd0, 8'h81); rd(2'd0, v); check("R4 bit0 set", v, 8'hFF);
        wr(2'd0, 8'h82); rd(2'd0, v); check("R4 bit1 set", v, 8'hFF);

        // R6: reserved mode bits
        wr(2'd2, 8'h05); rd(2'd2, v); check("R6 mode read", v, 8'hF5);

        // R9: oscillator ticks, low code bits ignored
        wr(2'd2, 8'h00); wr(2'd1, 8'h00);
        for (int i = 0; i < 5; i++) osc_pulse();
        rd(2'd1, v); check("R9 code0000", v, 8'h05);
        wr(2'd2, 8'h07);
        for (int i = 0; i < 3; i++) osc_pulse();
        rd(2'd1, v); check("R9 code0111", v, 8'h08);
        repeat (100) @(negedge clk);
        rd(2'd1, v); check("R9 idle", v, 8'h08);

        // R7: divided periods
        for (int c = 0; c < 7; c++) begin
            int expp;
            expp = (c == 6) ? 8192 : (64 << c);
            wr(2'd2, 8'h08 | c[7:0]);
            wr(2'd1, 8'h00);
            rd(2'd1, prev);
            t0 = -1; per = 0;
            for (int n = 0; n < 20000 && per == 0; n++) begin
                @(negedge clk); rd(2'd1, v);
                if (v != prev) begin
                    if (t0 >= 0) begin
                        per = n - t0;
                        check("R7 step", v, prev + 8'h01);
                    end
                    t0 = n; prev = v;
                end
            end
            check("R7 period", per, expp);
        end

        // R1: reset clears the flag and restores defaults
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        rd(2'd0, v); check("R1 flag cleared", v, 8'h7E);
        rd(2'd2, v); check("R1 mode again", v, 8'hFF);
        rst_n = 1'b1;

        // R5: guarded clear
        wr(2'd1, 8'hFE);
        repeat (4) @(negedge clk);
        wr(2'd2, 8'h00);
        rd(2'd0, v); check("R5 flag set", v, 8'h7F);
        wr(2'd0, 8'h80); rd(2'd0, v); check("R5 not yet", v, 8'hFF);
        wr(2'd0, 8'h80); rd(2'd0, v); check("R5 cleared", v, 8'hFE);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule